// File: doc/BRIEF.md
# Two-Input History Condition Detector

This block watches two single-bit inputs, `a_in` and `b_in`, once per clock and raises `z_out` in two situations. The first is a repeat on `a_in`: its value on the latest clock edge matches its value on the edge before. The second is a hold on `b_in`: `z_out` is already high and `b_in` is 1 again on the latest edge. The hold extends the high period for as long as `b_in` has stayed 1 on every edge since the repeat on `a_in` last occurred.

The block is a Moore machine with five named states on three D flip-flops. IDLE (000) means no history of `a_in` is known yet. SEEN0 (100) and SEEN1 (101) mean that `a_in` was last seen as 0 or 1 and `z_out` is low. HOLD0 (110) and HOLD1 (111) mean that `a_in` was last seen as 0 or 1 and `z_out` is high. The low bit of the state always holds the last sampled `a_in`, and the top bit is set in every state except IDLE. The codes 001, 010 and 011 are unused, and each leads back to IDLE.

The transitions work as follows. IDLE always moves to SEEN0 or SEEN1, following `a_in`. From any other state, a repeat on `a_in` moves to HOLD0 or HOLD1. A change on `a_in` while the machine is in a HOLD state with `b_in` at 1 moves to the other HOLD state. A change on `a_in` in any other case moves to SEEN0 or SEEN1. A synchronous reset returns the machine to IDLE. `z_out` is decoded from the present state only.

Top module: `hcd_detector`

## Requirements
- R1: While `rst` is 1 on a clock edge, the machine enters IDLE, and `z_out` is 0 after that edge.
- R2: The first edge after reset only records `a_in`: `z_out` stays 0 after it, whatever `a_in` and `b_in` are.
- R3: If `a_in` is 0 on two consecutive edges (not counting the first edge after reset as a history), `z_out` is 1 after the second of them.
- R4: If `a_in` is 1 on two consecutive edges, `z_out` is 1 after the second of them.
- R5: While `z_out` is 1 and `b_in` is 1 on an edge, `z_out` stays 1 after that edge, even when `a_in` changes.
- R6: If `b_in` is 0 on an edge and `a_in` differs from its value on the previous edge, `z_out` is 0 after that edge.
- R7: A repeat on `a_in` sets `z_out` to 1 after the edge whether `b_in` is 0 or 1.
- R8: `b_in` held at 1 with `a_in` changing on every edge never raises `z_out` when it starts low.
- R9: `z_out` changes only at a clock edge. A change on `a_in` or `b_in` between edges leaves it as it was.
- R10: A reset in the middle of a run clears the recorded `a_in`. A matching `a_in` on the first edge after reset does not raise `z_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 1 | Input sampled for the repeat check |
| b_in | input | 1 | Input that extends a high output |
| z_out | output | 1 | Moore output, decoded from the state register |

## Verification
Every result lands exactly one edge after the stimulus that causes it. The inputs sampled on an edge choose the next state, and `z_out` shows that state right after the same edge. The bench therefore drives `a_in` and `b_in` between edges, waits for the next rising edge, and compares `z_out` a short time after it against a model that applies the requirements edge by edge. For R9, the bench changes the inputs in the middle of a cycle and checks `z_out` again before the next edge.

// File: rtl/hcd_pkg.sv
package hcd_pkg;

    localparam int STATE_W = 3;

    // Bit 2: history known. Bit 1: output high. Bit 0: last sampled a_in.
    localparam int BIT_LIVE = 2;
    localparam int BIT_HIGH = 1;
    localparam int BIT_LASTA = 0;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE  = 3'b000,
        ST_SEEN0 = 3'b100,
        ST_SEEN1 = 3'b101,
        ST_HOLD0 = 3'b110,
        ST_HOLD1 = 3'b111
    } hcd_state_t;

endpackage

// File: rtl/hcd_next.sv
module hcd_next
    import hcd_pkg::*;
(
    input  hcd_state_t cur,
    input  logic       a_in,
    input  logic       b_in,
    output hcd_state_t nxt
);

    logic repeat_a;

    always_comb begin
        repeat_a = (a_in == cur[BIT_LASTA]);
        nxt = ST_IDLE;
        unique case (cur)
            ST_IDLE: begin
                // First sample after reset only records a_in.
                nxt = a_in ? ST_SEEN1 : ST_SEEN0;
            end
            ST_SEEN0, ST_SEEN1: begin
                if (repeat_a) nxt = a_in ? ST_HOLD1 : ST_HOLD0;
                else          nxt = a_in ? ST_SEEN1 : ST_SEEN0;
            end
            ST_HOLD0, ST_HOLD1: begin
                if (repeat_a || b_in) nxt = a_in ? ST_HOLD1 : ST_HOLD0;
                else                  nxt = a_in ? ST_SEEN1 : ST_SEEN0;
            end
            default: nxt = ST_IDLE; // unused codes 001, 010, 011
        endcase
    end

endmodule

// File: rtl/hcd_decode.sv
module hcd_decode
    import hcd_pkg::*;
(
    input  hcd_state_t cur,
    output logic       z,
    output logic       live,
    output logic       last_a
);

    always_comb begin
        z      = 1'b0;
        live   = 1'b0;
        last_a = 1'b0;
        unique case (cur)
            ST_IDLE: ;
            ST_SEEN0: live = 1'b1;
            ST_SEEN1: begin live = 1'b1; last_a = 1'b1; end
            ST_HOLD0: begin live = 1'b1; z = 1'b1; end
            ST_HOLD1: begin live = 1'b1; z = 1'b1; last_a = 1'b1; end
            default: ;
        endcase
    end

endmodule

// File: rtl/hcd_detector.sv
module hcd_detector
    import hcd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic a_in,
    input  logic b_in,
    output logic z_out
);

    hcd_state_t state_q;
    hcd_state_t state_d;
    logic       live;
    logic       last_a;
    logic       z_dec;

    hcd_next u_next (
        .cur  (state_q),
        .a_in (a_in),
        .b_in (b_in),
        .nxt  (state_d)
    );

    hcd_decode u_decode (
        .cur    (state_q),
        .z      (z_dec),
        .live   (live),
        .last_a (last_a)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Output process
    always_comb begin
        z_out = z_dec;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!z_out && !live));

    assert_first_sample_R2: assert property (@(posedge clk) disable iff (rst)
        !live |=> !z_out);

    assert_repeat_sets_R3: assert property (@(posedge clk) disable iff (rst)
        (live && a_in == last_a) |=> z_out);

    assert_hold_b_R5: assert property (@(posedge clk) disable iff (rst)
        (z_out && b_in) |=> z_out);

    assert_drop_R6: assert property (@(posedge clk) disable iff (rst)
        (!b_in && a_in != last_a) |=> !z_out);

    assert_history_a_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (last_a == $past(a_in) && live));

endmodule

// File: tb/tb_hcd_detector.sv
module tb_hcd_detector;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_in = 1'b0;
    logic b_in = 1'b0;
    logic z_out;

    int checks = 0;
    int errors = 0;

    // Bench model state
    logic m_live = 1'b0;
    logic m_last = 1'b0;
    logic m_z = 1'b0;

    hcd_detector dut (
        .clk   (clk),
        .rst   (rst),
        .a_in  (a_in),
        .b_in  (b_in),
        .z_out (z_out)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic exp);
        checks++;
        if (z_out !== exp) begin
            errors++;
            $display("FAIL %s: z_out=%b expected %b at %0t", req, z_out, exp, $time);
        end
    endtask

    // Apply one edge with the given inputs, update model, check after edge.
    task automatic step(input logic r, input logic a, input logic b, input string req);
        rst = r; a_in = a; b_in = b;
        @(posedge clk);
        if (r) begin
            m_live = 1'b0; m_z = 1'b0;
        end else if (!m_live) begin
            m_live = 1'b1; m_last = a; m_z = 1'b0;
        end else begin
            m_z = (a == m_last) || (m_z && b);
            m_last = a;
        end
        #1;
        check(req, m_z);
    endtask

    task automatic do_reset();
        step(1'b1, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b1, 1'b1, "R1");
    endtask

    task automatic t_reset_and_first();
        do_reset();
        step(1'b0, 1'b1, 1'b1, "R2");
        check("R2", 1'b0);
    endtask

    task automatic t_repeat_zero();
        do_reset();
        step(1'b0, 1'b0, 1'b0, "R2");
        step(1'b0, 1'b0, 1'b0, "R3");
        check("R3", 1'b1);
    endtask

    task automatic t_repeat_one();
        do_reset();
        step(1'b0, 1'b0, 1'b0, "R2");
        step(1'b0, 1'b1, 1'b0, "R4");
        step(1'b0, 1'b1, 1'b0, "R4");
        check("R4", 1'b1);
    endtask

    task automatic t_hold_and_drop();
        do_reset();
        step(1'b0, 1'b1, 1'b0, "R2");
        step(1'b0, 1'b1, 1'b0, "R4");
        for (int i = 0; i < 4; i++)
            step(1'b0, (i % 2 == 0), 1'b1, "R5");
        check("R5", 1'b1);
        step(1'b0, 1'b1, 1'b0, "R6");
        check("R6", 1'b0);
    endtask

    task automatic t_repeat_ignores_b();
        do_reset();
        step(1'b0, 1'b0, 1'b1, "R2");
        step(1'b0, 1'b0, 1'b0, "R7");
        check("R7", 1'b1);
        step(1'b0, 1'b1, 1'b0, "R6");
        step(1'b0, 1'b1, 1'b1, "R7");
        check("R7", 1'b1);
    endtask

    task automatic t_b_alone();
        do_reset();
        for (int i = 0; i < 8; i++)
            step(1'b0, i[0], 1'b1, "R8");
        check("R8", 1'b0);
    endtask

    task automatic t_between_edges();
        do_reset();
        step(1'b0, 1'b1, 1'b0, "R2");
        step(1'b0, 1'b1, 1'b0, "R4");
        #2; a_in = 1'b0; b_in = 1'b0;
        #2; check("R9", 1'b1);
        step(1'b0, 1'b0, 1'b0, "R6");
        #2; a_in = 1'b1; b_in = 1'b1;
        #2; check("R9", 1'b0);
    endtask

    task automatic t_mid_reset();
        do_reset();
        step(1'b0, 1'b1, 1'b0, "R2");
        step(1'b0, 1'b1, 1'b0, "R4");
        step(1'b1, 1'b1, 1'b1, "R1");
        check("R10", 1'b0);
        step(1'b0, 1'b1, 1'b1, "R10");
        check("R10", 1'b0);
        step(1'b0, 1'b1, 1'b0, "R4");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset_and_first();
        t_repeat_zero();
        t_repeat_one();
        t_hold_and_drop();
        t_repeat_ignores_b();
        t_b_alone();
        t_between_edges();
        t_mid_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule